// File: doc/BRIEF.md
# Shared Interrupt Swizzle Aggregator

Devices on a shared bus report changes to their interrupt pins as messages, not as wires. This block takes those messages and drives four shared interrupt lines. Each message gives a device/function number, one of four device pins, and the new level of that pin. The block uses the slot number to rotate the device pin onto one of the four bus lines. It remembers the last level it saw for every device pin, and it keeps a per-line count of the sources that are asserted. From that count each line behaves like a wired-OR of every device pin that maps onto it.

A source can send the same level twice, in either direction. Such a repeat does not change any count, so one device cannot drive a line high for good, and it cannot pull down a line that another device holds. The rotation rule is fixed per instance by a parameter. There are three rules: slot minus one, slot, and pass-through. The block accepts one message per clock and registers its four outputs.

Top module: `swz_top`

## Requirements
- R1: The slot is bits [7:3] of the 8-bit device/function number. Bits [2:0] are ignored. Two messages that differ only in those bits address the same stored pin state.
- R2: With SWIZZLE_MODE=0, a message for pin p of slot s acts on bus line (p + s - 1) mod 4.
- R3: With SWIZZLE_MODE=1, a message for pin p of slot s acts on bus line (p + s) mod 4.
- R4: With SWIZZLE_MODE=2, a message for pin p acts on bus line p, whatever the slot.
- R5: A bus line is high exactly when at least one stored device pin that maps onto it is high. A low message never raises a line, and a high message never lowers one.
- R6: A message that repeats the stored level of its device pin changes no line. Repeated lows do not underflow the count, and repeated highs do not add to it.
- R7: Reset clears every stored pin state and every line count, and drives all four lines low. After reset, a low message for a pin that was high before reset leaves all lines low.
- R8: evtReady is high from the first clock after reset. A message is taken on each rising edge where evtValid and evtReady are both high. Messages can arrive back to back, and the lines show the result right after the edge that takes the message.
- R9: When evtValid is low the lines hold their values, whatever the other inputs carry.
- R10: A single accepted message changes at most one bus line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| evtValid | input | 1 | A level-change message is present |
| evtReady | output | 1 | The block can take a message this cycle |
| evtDevfn | input | 8 | Device/function number of the source |
| evtPin | input | 2 | Device interrupt pin, 0 to 3 |
| evtLevel | input | 1 | New level of that pin |
| irqLine | output | 4 | Shared bus interrupt lines |

## Verification
The bench runs three instances side by side, one for each rotation rule. First it raises and then lowers every one of the 128 slot/pin pairs alone. A lone source shows on only one line, and that line tells the three rotation formulas apart. Next it raises all sources in order and lowers them in reverse, with repeated levels mixed in. A line may fall only when its last source drops, so this pass separates true counting from a plain last-writer or toggle scheme. Further passes cover function-bit aliasing, back-to-back messages, idle cycles with noisy inputs, a reset that comes while sources are high, and a long pseudo-random sequence checked against an arithmetic model.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int LINE_COUNT = 4;
  localparam int LINE_W     = 2;
  localparam int FUNC_W     = 3;

  localparam int SWZ_SLOT_MINUS_ONE = 0;
  localparam int SWZ_SLOT_PLUS      = 1;
  localparam int SWZ_PASS           = 2;

  typedef struct packed {
    logic              writeState;
    logic              incCount;
    logic              decCount;
    logic [LINE_W-1:0] lineSel;
    logic              newLevel;
  } dpStrobe_t;
endpackage

// File: rtl/swz_map.sv
module swz_map
  import swz_pkg::*;
#(
  parameter int SLOT_W       = 5,
  parameter int SWIZZLE_MODE = SWZ_SLOT_MINUS_ONE
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [LINE_W-1:0] pin,
  output logic [LINE_W-1:0] line
);
  logic [LINE_W-1:0] slotLow;
  assign slotLow = slot[LINE_W-1:0];

  generate
    if (SWIZZLE_MODE == SWZ_SLOT_MINUS_ONE) begin : gMinusOne
      assign line = pin + slotLow - LINE_W'(1);
    end else if (SWIZZLE_MODE == SWZ_SLOT_PLUS) begin : gPlus
      assign line = pin + slotLow;
    end else begin : gPass
      logic [LINE_W-1:0] unusedSlot;
      assign unusedSlot = slotLow;
      assign line = pin;
    end
  endgenerate
endmodule

// File: rtl/swz_ctrl.sv
module swz_ctrl
  import swz_pkg::*;
#(
  parameter int DEV_COUNT = 32,
  parameter int DEVFN_W   = 8,
  localparam int SLOT_W   = $clog2(DEV_COUNT),
  localparam int IDX_W    = SLOT_W + LINE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               evtValid,
  input  logic [DEVFN_W-1:0] evtDevfn,
  input  logic [LINE_W-1:0]  evtPin,
  input  logic               evtLevel,
  input  logic               storedLevel,
  input  logic [LINE_W-1:0]  mappedLine,
  output logic               evtReady,
  output logic [SLOT_W-1:0]  slot,
  output logic [IDX_W-1:0]   stateIdx,
  output dpStrobe_t          strb
);
  logic readyQ;
  logic accept;
  logic changed;

  always_ff @(posedge clk) begin
    if (rst) readyQ <= 1'b0;
    else     readyQ <= 1'b1;
  end

  assign evtReady = readyQ;
  assign accept   = evtValid & readyQ;
  assign slot     = evtDevfn[FUNC_W +: SLOT_W];
  assign stateIdx = {slot, evtPin};
  assign changed  = storedLevel ^ evtLevel;

  always_comb begin
    strb.writeState = accept;
    strb.incCount   = accept & changed & evtLevel;
    strb.decCount   = accept & changed & ~evtLevel;
    strb.lineSel    = mappedLine;
    strb.newLevel   = evtLevel;
  end
endmodule

// File: rtl/swz_datapath.sv
module swz_datapath
  import swz_pkg::*;
#(
  parameter int DEV_COUNT = 32,
  localparam int SLOT_W   = $clog2(DEV_COUNT),
  localparam int IDX_W    = SLOT_W + LINE_W,
  localparam int STATE_N  = DEV_COUNT * LINE_COUNT,
  localparam int CNT_W    = $clog2(DEV_COUNT + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [IDX_W-1:0]      stateIdx,
  input  dpStrobe_t             strb,
  output logic                  storedLevel,
  output logic [LINE_COUNT-1:0] irqLine
);
  logic [STATE_N-1:0] pinState;

  assign storedLevel = pinState[stateIdx];

  always_ff @(posedge clk) begin
    if (rst)                 pinState <= '0;
    else if (strb.writeState) pinState[stateIdx] <= strb.newLevel;
  end

  for (genvar g = 0; g < LINE_COUNT; g++) begin : gLine
    logic             hit;
    logic [CNT_W-1:0] srcCount;
    logic             lineBit;

    assign hit = (strb.lineSel == LINE_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        srcCount <= '0;
        lineBit  <= 1'b0;
      end else if (hit && strb.incCount) begin
        srcCount <= srcCount + CNT_W'(1);
        lineBit  <= 1'b1;
      end else if (hit && strb.decCount) begin
        srcCount <= srcCount - CNT_W'(1);
        lineBit  <= (srcCount != CNT_W'(1));
      end
    end

    assign irqLine[g] = lineBit;
  end
endmodule

// File: rtl/swz_top.sv
module swz_top
  import swz_pkg::*;
#(
  parameter int DEV_COUNT    = 32,
  parameter int DEVFN_W      = 8,
  parameter int SWIZZLE_MODE = SWZ_SLOT_MINUS_ONE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               evtValid,
  output logic               evtReady,
  input  logic [DEVFN_W-1:0] evtDevfn,
  input  logic [1:0]         evtPin,
  input  logic               evtLevel,
  output logic [3:0]         irqLine
);
  localparam int SLOT_W = $clog2(DEV_COUNT);
  localparam int IDX_W  = SLOT_W + LINE_W;

  logic [SLOT_W-1:0] slot;
  logic [IDX_W-1:0]  stateIdx;
  logic [LINE_W-1:0] mappedLine;
  logic              storedLevel;
  dpStrobe_t         strb;

  swz_map #(.SLOT_W(SLOT_W), .SWIZZLE_MODE(SWIZZLE_MODE)) uMap (
    .slot(slot), .pin(evtPin), .line(mappedLine)
  );

  swz_ctrl #(.DEV_COUNT(DEV_COUNT), .DEVFN_W(DEVFN_W)) uCtrl (
    .clk(clk), .rst(rst), .evtValid(evtValid), .evtDevfn(evtDevfn),
    .evtPin(evtPin), .evtLevel(evtLevel), .storedLevel(storedLevel),
    .mappedLine(mappedLine), .evtReady(evtReady), .slot(slot),
    .stateIdx(stateIdx), .strb(strb)
  );

  swz_datapath #(.DEV_COUNT(DEV_COUNT)) uDp (
    .clk(clk), .rst(rst), .stateIdx(stateIdx), .strb(strb),
    .storedLevel(storedLevel), .irqLine(irqLine)
  );
endmodule

// File: rtl/swz_checker.sv
module swz_checker #(
  parameter int SWIZZLE_MODE = 0
) (
  input logic       clk,
  input logic       rst,
  input logic       evtValid,
  input logic       evtReady,
  input logic [1:0] evtPin,
  input logic       evtLevel,
  input logic [3:0] irqLine
);
  logic accept;
  logic rstSeen;
  assign accept = evtValid & evtReady;

  always_ff @(posedge clk) begin
    rstSeen <= rst;
    if (rstSeen) AST_RESET_CLEAR: assert (irqLine == 4'b0000); // R7
  end

  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    !rst |=> evtReady); // R8
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(irqLine)); // R9
  AST_ONE_LINE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(irqLine ^ $past(irqLine)) <= 1)); // R10
  AST_LOW_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    (accept && !evtLevel) |=> ((irqLine & ~$past(irqLine)) == 4'b0000)); // R5
  AST_HIGH_NO_FALL: assert property (@(posedge clk) disable iff (rst)
    (accept && evtLevel) |=> ((~irqLine & $past(irqLine)) == 4'b0000)); // R5

  generate
    if (SWIZZLE_MODE == 2) begin : gPassChk
      AST_PASS_PIN: assert property (@(posedge clk) disable iff (rst)
        (accept && evtLevel) |=> irqLine[$past(evtPin)]); // R4
    end
  endgenerate
endmodule

bind swz_top swz_checker #(.SWIZZLE_MODE(SWIZZLE_MODE)) uChk (
  .clk(clk), .rst(rst), .evtValid(evtValid), .evtReady(evtReady),
  .evtPin(evtPin), .evtLevel(evtLevel), .irqLine(irqLine)
);

// File: tb/tb_swz_top.sv
module tb_swz_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       evtValid = 1'b0;
  logic [7:0] evtDevfn = '0;
  logic [1:0] evtPin = '0;
  logic       evtLevel = 1'b0;
  logic       rdy0, rdy1, rdy2;
  logic [3:0] line0, line1, line2;

  int checks = 0;
  int failures = 0;
  bit mdl [32][4];
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  swz_top #(.SWIZZLE_MODE(0)) dut (
    .clk(clk), .rst(rst), .evtValid(evtValid), .evtReady(rdy0),
    .evtDevfn(evtDevfn), .evtPin(evtPin), .evtLevel(evtLevel), .irqLine(line0));
  swz_top #(.SWIZZLE_MODE(1)) dutAlt (
    .clk(clk), .rst(rst), .evtValid(evtValid), .evtReady(rdy1),
    .evtDevfn(evtDevfn), .evtPin(evtPin), .evtLevel(evtLevel), .irqLine(line1));
  swz_top #(.SWIZZLE_MODE(2)) dutPass (
    .clk(clk), .rst(rst), .evtValid(evtValid), .evtReady(rdy2),
    .evtDevfn(evtDevfn), .evtPin(evtPin), .evtLevel(evtLevel), .irqLine(line2));

  function automatic int mapLine(int mode, int s, int p);
    if (mode == 0) return (p + s - 1) & 3;
    if (mode == 1) return (p + s) & 3;
    return p;
  endfunction

  function automatic logic [3:0] expLines(int mode);
    logic [3:0] e = '0;
    for (int s = 0; s < 32; s++)
      for (int p = 0; p < 4; p++)
        if (mdl[s][p]) e[mapLine(mode, s, p)] = 1'b1;
    return e;
  endfunction

  function automatic string modeReq(int mode);
    if (mode == 0) return "R2";
    if (mode == 1) return "R3";
    return "R4";
  endfunction

  task automatic checkLines(input string tag);
    logic [3:0] got [3];
    got[0] = line0; got[1] = line1; got[2] = line2;
    for (int m = 0; m < 3; m++) begin
      checks++;
      if (got[m] !== expLines(m)) begin
        failures++;
        $display("FAIL %s (%s) mode=%0d got=%b exp=%b", tag, modeReq(m), m, got[m], expLines(m));
      end
    end
  endtask

  task automatic clearModel();
    for (int s = 0; s < 32; s++)
      for (int p = 0; p < 4; p++) mdl[s][p] = 1'b0;
  endtask

  task automatic sendEvt(input logic [7:0] dfn, input int p, input bit lvl, input string tag);
    @(negedge clk);
    evtValid = 1'b1; evtDevfn = dfn; evtPin = 2'(p); evtLevel = lvl;
    @(negedge clk);
    evtValid = 1'b0;
    mdl[dfn[7:3]][p] = lvl;
    checkLines(tag);
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    clearModel();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired (R8) got=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clearModel();
    doReset();
    // R7 / R8: reset state and ready
    checkLines("R7 reset state");
    checks++;
    if ({rdy0, rdy1, rdy2} !== 3'b111) begin
      failures++;
      $display("FAIL R8 ready after reset got=%b exp=111", {rdy0, rdy1, rdy2});
    end

    // R2 R3 R4: every source alone
    for (int s = 0; s < 32; s++)
      for (int p = 0; p < 4; p++) begin
        sendEvt(8'(s << 3), p, 1'b1, "R2 R3 R4 lone source raise");
        sendEvt(8'(s << 3), p, 1'b0, "R5 lone source drop");
      end

    // R5: accumulate all, drop in reverse, with R6 repeats
    for (int s = 0; s < 32; s++)
      for (int p = 0; p < 4; p++)
        sendEvt(8'(s << 3), p, 1'b1, "R5 accumulate");
    sendEvt(8'(5 << 3), 2, 1'b1, "R6 repeated high");
    for (int s = 31; s >= 0; s--)
      for (int p = 3; p >= 0; p--) begin
        sendEvt(8'(s << 3), p, 1'b0, "R5 reverse drop");
        if (s == 20 && p == 1) sendEvt(8'(20 << 3), 1, 1'b0, "R6 repeated low midway");
      end
    sendEvt(8'h00, 0, 1'b0, "R6 repeated low no underflow");
    sendEvt(8'h08, 0, 1'b1, "R6 raise after repeated low");
    sendEvt(8'h08, 0, 1'b0, "R6 drop after repeated low");

    // R1: function bits alias
    sendEvt(8'((7 << 3) | 5), 1, 1'b1, "R1 raise with function 5");
    sendEvt(8'((7 << 3) | 2), 1, 1'b0, "R1 drop with function 2");
    sendEvt(8'((9 << 3) | 7), 3, 1'b1, "R1 raise with function 7");
    sendEvt(8'((9 << 3) | 7), 3, 1'b1, "R1 R6 repeat same slot");
    sendEvt(8'(9 << 3), 3, 1'b0, "R1 drop with function 0");

    // R8: back-to-back messages
    @(negedge clk);
    evtValid = 1'b1; evtDevfn = 8'(3 << 3); evtPin = 2'd0; evtLevel = 1'b1;
    @(negedge clk);
    mdl[3][0] = 1'b1;
    checkLines("R8 back-to-back first");
    evtDevfn = 8'(6 << 3); evtPin = 2'd2; evtLevel = 1'b1;
    @(negedge clk);
    evtValid = 1'b0;
    mdl[6][2] = 1'b1;
    checkLines("R8 back-to-back second");

    // R9: idle with noisy inputs
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      evtDevfn = 8'(k * 37); evtPin = 2'(k); evtLevel = k[0];
      @(negedge clk);
      checkLines("R9 idle inputs ignored");
    end

    // R7: reset while sources high, then stale low message
    sendEvt(8'(12 << 3), 1, 1'b1, "R5 pre-reset raise");
    doReset();
    checkLines("R7 reset clears lines");
    sendEvt(8'(12 << 3), 1, 1'b0, "R7 stale low after reset");
    sendEvt(8'(3 << 3), 0, 1'b0, "R7 stale low after reset");
    sendEvt(8'(12 << 3), 1, 1'b1, "R7 raise after reset");
    sendEvt(8'(12 << 3), 1, 1'b0, "R7 drop after reset");

    // R5 R6 pseudo-random mix
    for (int k = 0; k < 600; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sendEvt(lfsr[7:0], int'(lfsr[9:8]), lfsr[10] ^ lfsr[14], "R5 R6 random mix");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule